// File: doc/BRIEF.md
# BCD Real-Time Clock and Calendar Counter

This block keeps time of day and calendar date as binary-coded decimal fields, stepping once for every pulse on its hundredths-of-a-second tick input. It holds eight running counters: hundredths, seconds, minutes, hours, weekday, day of month, month and year. Carries ripple from the finest field to the coarsest. It handles short months, a leap-year February and a 12-hour AM/PM display mode.

Software sees a second bank of eight bytes, the visible copies, through a byte-wide port sampled on the system clock. The port has active-low chip select, output enable and write enable, a 6-bit address and separate data-in and data-out buses. The visible bank is refreshed from the running bank in one simultaneous transfer after each change. The transfer is held off while a read is in progress, so that consecutive reads are not torn by a carry. A write loads one running counter when the write cycle ends.

The bus controller is a three-state machine:
- BUS_IDLE goes to BUS_WRITE on select with write enable, or to BUS_READ on select with output enable.
- BUS_READ returns to BUS_IDLE when select or output enable is released, or goes to BUS_WRITE when write enable falls.
- BUS_WRITE returns to BUS_IDLE, with a commit, when select or write enable rises.

Top module: `rtc_timekeeper`

## Requirements
- R1: Byte 0 (hundredths, 00-99), byte 1 (seconds, 00-59) and byte 2 (minutes, 00-59) count in BCD. A field at its limit returns to 00 and carries into the next field.
- R2: In 24-hour mode (byte 3 bit 6 clear), bits 5:0 of byte 3 hold hours 00-23 in BCD. Hour 23 wraps to 00 and carries into the weekday and date.
- R3: In 12-hour mode (byte 3 bit 6 set), bit 5 is the PM flag and bits 4:0 hold hours 01-12 in BCD. Hour 11 steps to 12 and toggles the flag; hour 12 steps to 01. Only 11 PM to 12 AM carries into the date.
- R4: Byte 5 (date) wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Byte 6 (month, 01-12) wraps 12 to 01 and carries into the year.
- R5: In February the date wraps after 29 when the BCD year in byte 7 is a multiple of four, and after 28 otherwise.
- R6: Byte 4 (weekday, 01-07) advances on every date carry and wraps from 07 to 01.
- R7: Byte 7 (year, 00-99) wraps from 99 to 00.
- R8: A read needs chip select and output enable low and write enable high. The data output is enabled from the next cycle and carries the visible byte at the address. Addresses 8 to 63 read 00.
- R9: A write needs chip select and write enable low. It commits the data present in the last cycle before either signal rises, into that running field only. Writes to addresses 8 to 63 are ignored.
- R10: Write enable falling during a read disables the data output in the next cycle.
- R11: All visible bytes take the running values together, one cycle after a running change, but not while a read is active. A deferred transfer happens after the read ends.
- R12: Invalid BCD values are stored unchecked. A field at or above its limit wraps on the next step, and it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per hundredth of a second |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 6 | Register address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Read data output enable |

## Verification
A tick sampled at one edge changes the running counters at that edge and reaches the visible bank one edge later. Each bench tick task therefore leaves a spare cycle before any read.

A write commits at the first edge where select or write enable is seen high, and its value becomes visible one edge after that. The write task idles for two cycles before it returns.

The data output is enabled one edge after select and output enable fall. The monitor compares the byte at the first falling clock edge where the enable is high. The read-hold and write-enable cases are checked directly at falling edges, counted from the cycle of the stimulus.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NF     = 8;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    typedef logic [NF-1:0][DATA_W-1:0] rtc_bank_t;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_READ,
        BUS_WRITE
    } bus_state_t;

    localparam int F_HUND = 0;
    localparam int F_SEC  = 1;
    localparam int F_MIN  = 2;
    localparam int F_HOUR = 3;
    localparam int F_DOW  = 4;
    localparam int F_DATE = 5;
    localparam int F_MON  = 6;
    localparam int F_YEAR = 7;
endpackage

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              rd_active,
    output logic              ld_en,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data
);
    bus_state_t state, state_nx;
    logic       wr_req, rd_req;

    assign wr_req = !ce_n && !we_n;
    assign rd_req = !ce_n && !oe_n;

    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_IDLE:  if (wr_req) state_nx = BUS_WRITE;
                       else if (rd_req) state_nx = BUS_READ;
            BUS_READ:  if (wr_req) state_nx = BUS_WRITE;
                       else if (!rd_req) state_nx = BUS_IDLE;
            BUS_WRITE: if (!wr_req) state_nx = BUS_IDLE;
            default:   state_nx = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_addr <= '0;
            ld_data <= '0;
        end else if (wr_req) begin
            ld_data <= din;
            if (state != BUS_WRITE) ld_addr <= addr;
        end
    end

    always_comb begin
        rd_active = (state == BUS_READ);
        ld_en     = (state == BUS_WRITE) && !wr_req;
    end

    a_r8_read_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> $past(!ce_n && !oe_n && we_n));
    a_r10_write_cuts_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && !we_n && !ce_n) |=> !rd_active);
    a_r9_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> !ld_en);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output rtc_bank_t         cnt
);
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
    endfunction

    function automatic logic is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    rtc_bank_t  nx;
    logic       c_sec, c_min, c_hr, c_day, c_mon, c_yr;
    logic [7:0] dim, hr12, hr24;

    always_comb begin
        unique case (cnt[F_MON])
            8'h02:                      dim = is_leap(cnt[F_YEAR]) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: dim = 8'h30;
            default:                    dim = 8'h31;
        endcase
    end

    always_comb begin
        nx    = cnt;
        hr12  = {3'b000, cnt[F_HOUR][4:0]};
        hr24  = {2'b00, cnt[F_HOUR][5:0]};
        c_sec = tick && (cnt[F_HUND] >= 8'h99);
        c_min = c_sec && (cnt[F_SEC] >= 8'h59);
        c_hr  = c_min && (cnt[F_MIN] >= 8'h59);
        c_day = 1'b0;
        if (tick)  nx[F_HUND] = (cnt[F_HUND] >= 8'h99) ? 8'h00 : bcd_inc(cnt[F_HUND]);
        if (c_sec) nx[F_SEC]  = (cnt[F_SEC]  >= 8'h59) ? 8'h00 : bcd_inc(cnt[F_SEC]);
        if (c_min) nx[F_MIN]  = (cnt[F_MIN]  >= 8'h59) ? 8'h00 : bcd_inc(cnt[F_MIN]);
        if (c_hr) begin
            if (cnt[F_HOUR][6]) begin
                if (hr12 >= 8'h12) begin
                    nx[F_HOUR][4:0] = 5'h01;
                end else if (hr12 == 8'h11) begin
                    nx[F_HOUR][4:0] = 5'h12;
                    nx[F_HOUR][5]   = !cnt[F_HOUR][5];
                    c_day           = cnt[F_HOUR][5];
                end else begin
                    nx[F_HOUR][4:0] = bcd_inc(hr12)[4:0];
                end
            end else begin
                c_day           = (hr24 >= 8'h23);
                nx[F_HOUR][5:0] = c_day ? 6'h00 : bcd_inc(hr24)[5:0];
            end
        end
        c_mon = c_day && (cnt[F_DATE] >= dim);
        c_yr  = c_mon && (cnt[F_MON] >= 8'h12);
        if (c_day) begin
            nx[F_DOW]  = (cnt[F_DOW] >= 8'h07) ? 8'h01 : bcd_inc(cnt[F_DOW]);
            nx[F_DATE] = c_mon ? 8'h01 : bcd_inc(cnt[F_DATE]);
        end
        if (c_mon) nx[F_MON]  = c_yr ? 8'h01 : bcd_inc(cnt[F_MON]);
        if (c_yr)  nx[F_YEAR] = (cnt[F_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(cnt[F_YEAR]);
        if (ld_en && (ld_addr < ADDR_W'(NF))) nx[ld_addr[2:0]] = ld_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            cnt[F_DOW]  <= 8'h01;
            cnt[F_DATE] <= 8'h01;
            cnt[F_MON]  <= 8'h01;
        end else begin
            cnt <= nx;
        end
    end

    a_r1_hund_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && cnt[F_HUND] == 8'h99) |=> cnt[F_HUND] == 8'h00);
    a_r7_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && c_yr && cnt[F_YEAR] == 8'h99) |=> cnt[F_YEAR] == 8'h00);
    a_r6_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && c_day && cnt[F_DOW] == 8'h07) |=> cnt[F_DOW] == 8'h01);
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [5:0]  addr,
    input  logic [7:0]  dq_in,
    output logic [7:0]  dq_out,
    output logic        dq_oe
);
    logic              ld_en, rd_active, pend, xfer;
    logic [ADDR_W-1:0] ld_addr;
    logic [DATA_W-1:0] ld_data;
    rtc_bank_t         core_q, shadow_q;

    rtc_bus_fsm u_bus (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(dq_in), .rd_active(rd_active), .ld_en(ld_en),
        .ld_addr(ld_addr), .ld_data(ld_data)
    );

    rtc_calendar_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ld_en(ld_en),
        .ld_addr(ld_addr), .ld_data(ld_data), .cnt(core_q)
    );

    assign xfer = pend && !rd_active;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b1;
            shadow_q <= '0;
        end else begin
            if (xfer) shadow_q <= core_q;
            pend <= tick || ld_en || (pend && !xfer);
        end
    end

    assign dq_oe  = rd_active;
    assign dq_out = (addr < ADDR_W'(NF)) ? shadow_q[addr[2:0]] : '0;

    a_r11_bulk_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> shadow_q == $past(core_q));
    a_r11_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && $past(rd_active)) |-> $stable(shadow_q));
endmodule

// File: tb/rtc_timekeeper_bench.sv
module rtc_timekeeper_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe;

    int         n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       oe_prev = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    rtc_timekeeper u_rtc_timekeeper (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares the first enabled read byte against the queue
    always @(negedge clk) begin
        if (dq_oe && !oe_prev) begin
            if (exp_q.size() == 0) chk("R8 unexpected read", dq_out, 8'hxx);
            else chk(tag_q.pop_front(), dq_out, exp_q.pop_front());
        end
        oe_prev = dq_oe;
    end

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
        @(negedge clk); ce_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; dq_in = d; ce_n = 0; we_n = 0;
        @(negedge clk); ce_n = 1; we_n = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic step();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        @(negedge clk);
    endtask

    task automatic roll_day(input logic [7:0] hr, input logic [7:0] dt,
                            input logic [7:0] mo, input logic [7:0] yr);
        wr(0, 8'h99); wr(1, 8'h59); wr(2, 8'h59); wr(3, hr);
        wr(5, dt); wr(6, mo); wr(7, yr);
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got hang expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R8 reset oe", {7'd0, dq_oe}, 8'h00);
        rd(0, 8'h00, "R1 reset hund");
        rd(4, 8'h01, "R6 reset dow");

        // full carry chain: every field wraps
        wr(4, 8'h07);
        roll_day(8'h23, 8'h31, 8'h12, 8'h99);
        rd(0, 8'h00, "R1 hund wrap");
        rd(1, 8'h00, "R1 sec wrap");
        rd(2, 8'h00, "R1 min wrap");
        rd(3, 8'h00, "R2 hour 23 to 00");
        rd(4, 8'h01, "R6 dow 7 to 1");
        rd(5, 8'h01, "R4 date 31 to 01");
        rd(6, 8'h01, "R4 month 12 to 01");
        rd(7, 8'h00, "R7 year 99 to 00");

        // February and short months
        roll_day(8'h23, 8'h28, 8'h02, 8'h24);
        rd(5, 8'h29, "R5 leap 24 feb 28 to 29");
        rd(6, 8'h02, "R5 leap stays feb");
        roll_day(8'h23, 8'h29, 8'h02, 8'h24);
        rd(5, 8'h01, "R5 leap feb 29 wraps");
        rd(6, 8'h03, "R5 leap to march");
        roll_day(8'h23, 8'h28, 8'h02, 8'h23);
        rd(5, 8'h01, "R5 year 23 feb 28 wraps");
        roll_day(8'h23, 8'h28, 8'h02, 8'h10);
        rd(5, 8'h01, "R5 year 10 not leap");
        roll_day(8'h23, 8'h28, 8'h02, 8'h12);
        rd(5, 8'h29, "R5 year 12 leap");
        roll_day(8'h23, 8'h30, 8'h04, 8'h12);
        rd(5, 8'h01, "R4 april 30 wraps");
        rd(6, 8'h05, "R4 april to may");
        roll_day(8'h23, 8'h30, 8'h11, 8'h12);
        rd(6, 8'h12, "R4 november to december");
        roll_day(8'h23, 8'h30, 8'h01, 8'h12);
        rd(5, 8'h31, "R4 january has 31");

        // 12-hour mode
        roll_day(8'h51, 8'h05, 8'h01, 8'h12);
        rd(3, 8'h72, "R3 11AM to 12PM");
        rd(5, 8'h05, "R3 no day carry at noon");
        roll_day(8'h52, 8'h05, 8'h01, 8'h12);
        rd(3, 8'h41, "R3 12AM to 01AM");
        wr(4, 8'h03);
        roll_day(8'h71, 8'h05, 8'h01, 8'h12);
        rd(3, 8'h52, "R3 11PM to 12AM");
        rd(5, 8'h06, "R3 midnight carries date");
        rd(4, 8'h04, "R6 dow advances");

        // invalid BCD
        wr(2, 8'h05); wr(1, 8'h7A); wr(0, 8'h99);
        step();
        rd(1, 8'h00, "R12 invalid sec wraps");
        rd(2, 8'h06, "R12 invalid sec carries");

        // read holds the visible bank
        wr(0, 8'h10);
        exp_q.push_back(8'h10); tag_q.push_back("R8 read hund");
        @(negedge clk); addr = 0; ce_n = 0; oe_n = 0;
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 held during read", dq_out, 8'h10);
        ce_n = 1; oe_n = 1;
        @(negedge clk);
        @(negedge clk);
        rd(0, 8'h11, "R11 deferred transfer");

        // write enable falling during a read
        wr(7, 8'h30);
        exp_q.push_back(8'h30); tag_q.push_back("R9 write year");
        @(negedge clk); addr = 7; ce_n = 0; oe_n = 0;
        @(negedge clk); we_n = 0; dq_in = 8'h24;
        @(negedge clk);
        chk("R10 output cut", {7'd0, dq_oe}, 8'h00);
        we_n = 1; ce_n = 1; oe_n = 1;
        repeat (3) @(negedge clk);
        rd(7, 8'h24, "R9 write from read");

        // unmapped addresses
        wr(20, 8'h55);
        rd(20, 8'h00, "R8 unmapped reads zero");
        rd(7, 8'h24, "R9 unmapped write ignored");
        rd(6, 8'h01, "R9 other field intact");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("R8 pending reads", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule